// File: doc/BRIEF.md
# Indirect Control-Memory Access Port

This block sits between a microprocessor register bus and the single-port control memory of a time-slot switch. Each control-memory word is 14 bits: an 8-bit data byte and a 6-bit code. The processor never addresses the memory directly. It goes through three registers instead:
- an address register, whose most significant bit picks read or write;
- a data register for the byte;
- a code register for the 6-bit code.

A status register reports a busy flag and a sticky collision flag.

Writing the address register is the trigger for the access. A write stores the current data and code at the addressed word. A read loads the data and code registers from the addressed word. The switch scans the same memory with its own cyclic reads, and those reads always win. The processor access is placed in the first cycle the switch leaves free. As long as the switch never requests for more than `SW_RUN_MAX` cycles in a row, every access finishes within a fixed number of clock cycles. That bound lies well inside a 488 ns completion budget.

The sequencer has three states:
- `SQ_IDLE`: no access is pending. An accepted address write (`start`) moves it to `SQ_PEND`.
- `SQ_PEND`: it requests the memory. On a grant it moves to `SQ_IDLE` for a write, or to `SQ_RDCAP` for a read.
- `SQ_RDCAP`: it captures the word returned by the synchronous memory into the data and code registers, then moves to `SQ_IDLE`.

Top module: `cm_access_port`

## Requirements
- R1: After reset the address, data and code registers read 0, and the status register reads 0 (bit 0 busy = 0, bit 1 collision = 0).
- R2: `cpu_sel` selects the register: 0 = address (bits 8:0, bit 8 = read mode), 1 = data (bits 7:0), 2 = code (bits 5:0), 3 = status. `cpu_rdata` returns the selected register zero-extended, combinationally. Writes to data and code take effect at the next clock edge when not busy.
- R3: A write to the address register while idle starts exactly one access. Busy reads 1 from the following cycle until the access ends.
- R4: With address bit 8 = 0, the word {code, data} is stored at the address, code in bits 13:8 and data in bits 7:0. A switch read of an address returns the word on `sw_rdata` with `sw_vld` = 1 one cycle after `sw_req`.
- R5: With address bit 8 = 1, the data and code registers hold the addressed word's bits 7:0 and 13:8 once busy drops.
- R6: The processor access uses only a cycle in which `sw_req` is 0. A switch read is never displaced or corrupted.
- R7: If `sw_req` never stays high for more than `SW_RUN_MAX` (3) consecutive cycles, busy lasts at most `SW_RUN_MAX`+1 cycles for a write and `SW_RUN_MAX`+2 for a read. It lasts exactly that long when the switch holds the memory for `SW_RUN_MAX` cycles.
- R8: An address write while busy is ignored: the address register and the memory keep their values, and status bit 1 is set. That bit stays set until a status write with bit 1 = 1.
- R9: Writes to the data or code register while busy are ignored.
- R10: Addresses at or above `DEPTH` (192) leave the memory unchanged on a write and return 0 data and 0 code on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select |
| cpu_wdata | input | 9 | Register write data |
| cpu_rdata | output | 9 | Selected register contents |
| sw_req | input | 1 | Cyclic switch read request |
| sw_addr | input | 8 | Switch read address |
| sw_vld | output | 1 | Switch read data valid |
| sw_rdata | output | 14 | Control-memory word for the switch |

## Verification
Writes and reads run against three switch-traffic patterns, and each pattern separates a different fault:
- No switch traffic checks the minimum busy length.
- A switch hold of exactly `SW_RUN_MAX` cycles pins the worst-case busy length. That separates a missing priority stage from an extra one.
- Random capped switch traffic, with every switch read compared to a reference memory, shows whether a processor write ever lands in a switch cycle or too early.

Directed cases add a second address write inside a busy window, a data write inside the same window, and accesses beyond the last word. Together they tell ignored stimulus apart from stimulus that leaks through.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int CM_DEPTH      = 192;
    localparam int CM_ADDR_W     = 8;
    localparam int CM_DATA_W     = 8;
    localparam int CM_CODE_W     = 6;
    localparam int CM_SW_RUN_MAX = 3;

    typedef enum logic [1:0] {
        SEL_DEST = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_CODE = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PEND  = 2'd1,
        SQ_RDCAP = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cm_mem.sv
module cm_mem #(
    parameter int DEPTH  = 192,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [DEPTH];
    logic              in_range;

    // A full power-of-two depth needs no range decode.
    generate
        if (DEPTH >= (1 << ADDR_W)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (int'(addr) < DEPTH);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (en && we && in_range) begin
            store[addr] <= wdata;
        end
        if (en && !we) begin
            rdata <= in_range ? store[addr] : '0;
        end
    end

endmodule

// File: rtl/cm_arb.sv
module cm_arb #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_word,
    output logic              gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              sw_vld
);

    // Switch scan owns the port whenever it asks.
    assign gnt       = cpu_req & ~sw_req;
    assign mem_en    = sw_req | gnt;
    assign mem_we    = gnt & cpu_we;
    assign mem_addr  = sw_req ? sw_addr : cpu_addr;
    assign mem_wdata = cpu_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_vld <= 1'b0;
        end else begin
            sw_vld <= sw_req;
        end
    end

endmodule

// File: rtl/cm_seq.sv
module cm_seq
    import cm_pkg::*;
#(
    parameter int SW_RUN_MAX = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_mode,
    input  logic gnt,
    output logic busy,
    output logic cpu_req,
    output logic cpu_we,
    output logic rd_load
);

    localparam int ACC_LIMIT = SW_RUN_MAX + 2;
    localparam int CNT_W     = $clog2(ACC_LIMIT + 2) + 1;

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (start) state_d = SQ_PEND;
            SQ_PEND:  if (gnt)   state_d = rd_mode ? SQ_RDCAP : SQ_IDLE;
            SQ_RDCAP: state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        rd_load = 1'b0;
        unique case (state_q)
            SQ_IDLE:  ;
            SQ_PEND: begin
                busy    = 1'b1;
                cpu_req = 1'b1;
                cpu_we  = ~rd_mode;
            end
            SQ_RDCAP: begin
                busy    = 1'b1;
                rd_load = 1'b1;
            end
            default: ;
        endcase
    end

    // Busy-window length tracker for the completion bound check.
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_cnt <= '0;
        end else if (busy_cnt != {CNT_W{1'b1}}) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);                                                      // R3

    AST_ACCESS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(busy_cnt) < ACC_LIMIT));                               // R7

endmodule

// File: rtl/cm_regs.sv
module cm_regs
    import cm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CODE_W = 6,
    parameter int BUS_W  = ADDR_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_wr,
    input  logic [1:0]               cpu_sel,
    input  logic [BUS_W-1:0]         cpu_wdata,
    output logic [BUS_W-1:0]         cpu_rdata,
    input  logic                     busy,
    input  logic                     rd_load,
    input  logic [DATA_W+CODE_W-1:0] rd_word,
    output logic                     start,
    output logic [ADDR_W:0]          dest_q,
    output logic [DATA_W-1:0]        src_q,
    output logic [CODE_W-1:0]        code_q
);

    localparam int WORD_W = DATA_W + CODE_W;

    reg_sel_e sel;
    logic     wr_dest, wr_src, wr_code, wr_stat;
    logic     collide;
    logic     err_q;

    assign sel     = reg_sel_e'(cpu_sel);
    assign wr_dest = cpu_wr && (sel == SEL_DEST);
    assign wr_src  = cpu_wr && (sel == SEL_SRC);
    assign wr_code = cpu_wr && (sel == SEL_CODE);
    assign wr_stat = cpu_wr && (sel == SEL_STAT);
    assign start   = wr_dest && !busy;
    assign collide = wr_dest && busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= '0;
        end else if (start) begin
            dest_q <= cpu_wdata[ADDR_W:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            code_q <= '0;
        end else if (rd_load) begin
            src_q  <= rd_word[DATA_W-1:0];
            code_q <= rd_word[WORD_W-1:DATA_W];
        end else if (!busy) begin
            if (wr_src)  src_q  <= cpu_wdata[DATA_W-1:0];
            if (wr_code) code_q <= cpu_wdata[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (collide) begin
            err_q <= 1'b1;
        end else if (wr_stat && cpu_wdata[1]) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (sel)
            SEL_DEST: cpu_rdata[ADDR_W:0]   = dest_q;
            SEL_SRC:  cpu_rdata[DATA_W-1:0] = src_q;
            SEL_CODE: cpu_rdata[CODE_W-1:0] = code_q;
            SEL_STAT: cpu_rdata[1:0]        = {err_q, busy};
            default:  cpu_rdata = '0;
        endcase
    end

    AST_COLLIDE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> ($stable(dest_q) && err_q));                              // R8

    AST_BUSY_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_src && busy && !rd_load) |=> $stable(src_q));                     // R9

    AST_BUSY_CODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_code && busy && !rd_load) |=> $stable(code_q));                   // R9

endmodule

// File: rtl/cm_access_port.sv
module cm_access_port
    import cm_pkg::*;
#(
    parameter int DEPTH      = CM_DEPTH,
    parameter int ADDR_W     = CM_ADDR_W,
    parameter int DATA_W     = CM_DATA_W,
    parameter int CODE_W     = CM_CODE_W,
    parameter int SW_RUN_MAX = CM_SW_RUN_MAX,
    parameter int BUS_W      = ADDR_W + 1,
    parameter int WORD_W     = DATA_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_sel,
    input  logic [BUS_W-1:0]  cpu_wdata,
    output logic [BUS_W-1:0]  cpu_rdata,
    input  logic              sw_req,
    input  logic [ADDR_W-1:0] sw_addr,
    output logic              sw_vld,
    output logic [WORD_W-1:0] sw_rdata
);

    logic              start, busy, cpu_req, cpu_we, rd_load, gnt;
    logic [ADDR_W:0]   dest_q;
    logic [DATA_W-1:0] src_q;
    logic [CODE_W-1:0] code_q;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;

    cm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CODE_W (CODE_W),
        .BUS_W  (BUS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .busy      (busy),
        .rd_load   (rd_load),
        .rd_word   (mem_rdata),
        .start     (start),
        .dest_q    (dest_q),
        .src_q     (src_q),
        .code_q    (code_q)
    );

    cm_seq #(
        .SW_RUN_MAX (SW_RUN_MAX)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_mode (dest_q[ADDR_W]),
        .gnt     (gnt),
        .busy    (busy),
        .cpu_req (cpu_req),
        .cpu_we  (cpu_we),
        .rd_load (rd_load)
    );

    cm_arb #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_req    (sw_req),
        .sw_addr   (sw_addr),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (dest_q[ADDR_W-1:0]),
        .cpu_word  ({code_q, src_q}),
        .gnt       (gnt),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sw_vld    (sw_vld)
    );

    cm_mem #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign sw_rdata = mem_rdata;

    AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |-> (!mem_we && mem_addr == sw_addr));                         // R6

    AST_SW_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> sw_vld);                                                   // R4

endmodule

// File: tb/cm_access_port_tb.sv
module cm_access_port_tb;

    localparam int DEPTH  = 192;
    localparam int ADDR_W = 8;
    localparam int SWMAX  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic [8:0]  cpu_wdata = '0;
    logic [8:0]  cpu_rdata;
    logic        sw_req = 1'b0;
    logic [7:0]  sw_addr = '0;
    logic        sw_vld;
    logic [13:0] sw_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [13:0] model [DEPTH];
    bit          known [DEPTH];
    logic [7:0]  cur_src = '0;
    logic [5:0]  cur_code = '0;

    always #10 clk = ~clk;

    cm_access_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .sw_req    (sw_req),
        .sw_addr   (sw_addr),
        .sw_vld    (sw_vld),
        .sw_rdata  (sw_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] exp_read(input logic [7:0] a);
        if (int'(a) >= DEPTH) return 14'd0;
        return model[a];
    endfunction

    task automatic rd_reg(input logic [1:0] s, output logic [8:0] v);
        cpu_sel = s;
        #1;
        v = cpu_rdata;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [8:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic sw_read_chk(input logic [7:0] a, input string tag);
        @(negedge clk);
        sw_req = 1'b1; sw_addr = a;
        @(negedge clk);
        sw_req = 1'b0;
        chk({tag, " sw_vld"}, 32'(sw_vld), 32'd1);
        chk({tag, " sw_rdata"}, 32'(sw_rdata), 32'(model[a]));
    endtask

    // mode 0: no switch traffic, 1: random capped runs, 2: hold for `hold` cycles
    task automatic do_access(input bit rd, input logic [7:0] a, input int mode, input int hold,
                             output int cnt);
        logic [8:0] v;
        bit         prev;
        logic [13:0] prev_exp;
        bit         prev_known;
        int         run;
        wr_reg(2'd0, {rd, a});
        rd_reg(2'd3, v);
        chk("R3 busy after address write", 32'(v[0]), 32'd1);
        cnt = 0; prev = 0; run = 0; prev_exp = '0; prev_known = 0;
        forever begin
            if (prev && prev_known) begin
                chk("R6 switch read during access", 32'(sw_rdata), 32'(prev_exp));
            end
            rd_reg(2'd3, v);
            if (!v[0]) break;
            cnt++;
            if (cnt > 40) begin
                chk("R7 access never ended", 32'(cnt), 32'd0);
                break;
            end
            prev = 0;
            if (mode == 2) prev = (cnt <= hold);
            else if (mode == 1) prev = (run < SWMAX) && ($urandom % 2 == 1);
            run = prev ? run + 1 : 0;
            sw_req = prev;
            sw_addr = 8'($urandom % DEPTH);
            prev_exp = model[sw_addr];
            prev_known = known[sw_addr];
            @(negedge clk);
        end
        sw_req = 1'b0;
        if (!rd && int'(a) < DEPTH) begin
            model[a] = {cur_code, cur_src};
            known[a] = 1'b1;
        end
    endtask

    task automatic set_src_code(input logic [7:0] s, input logic [5:0] c);
        wr_reg(2'd1, {1'b0, s});
        wr_reg(2'd2, {3'b0, c});
        cur_src = s; cur_code = c;
    endtask

    task automatic check_read_back(input logic [7:0] a, input string tag);
        logic [8:0]  v;
        logic [13:0] e;
        e = exp_read(a);
        rd_reg(2'd1, v);
        chk({tag, " data"}, 32'(v), 32'(e[7:0]));
        rd_reg(2'd2, v);
        chk({tag, " code"}, 32'(v), 32'(e[13:8]));
        cur_src = e[7:0]; cur_code = e[13:8];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] v;
        int cnt;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin model[i] = '0; known[i] = 1'b0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            chk("R1 register after reset", 32'(v), 32'd0);
        end

        // R2 register select and readback
        set_src_code(8'h5A, 6'h2B);
        rd_reg(2'd1, v); chk("R2 data readback", 32'(v), 32'h5A);
        rd_reg(2'd2, v); chk("R2 code readback", 32'(v), 32'h2B);

        // Fill every word, minimum busy with no switch traffic on even words
        for (int a = 0; a < DEPTH; a++) begin
            set_src_code(8'((a * 37 + 11) & 8'hFF), 6'((a * 5 + 3) & 6'h3F));
            do_access(1'b0, 8'(a), (a % 2 == 0) ? 0 : 1, 0, cnt);
            if (a % 2 == 0) chk("R7 minimum write busy", 32'(cnt), 32'd1);
            else if (cnt > SWMAX + 1) chk("R7 write busy bound", 32'(cnt), 32'(SWMAX + 1));
        end
        rd_reg(2'd0, v);
        chk("R2 address readback", 32'(v), 32'(DEPTH - 1));

        // R4 switch reads of stored words
        for (int k = 0; k < 8; k++) sw_read_chk(8'($urandom % DEPTH), "R4");

        // Random mix of reads and writes under capped switch traffic
        for (int k = 0; k < 300; k++) begin
            logic [7:0] a;
            bit rd;
            rd = ($urandom % 2 == 1);
            a  = 8'($urandom % 200);
            if (!rd) set_src_code(8'($urandom), 6'($urandom));
            do_access(rd, a, 1, 0, cnt);
            if (cnt > (rd ? SWMAX + 2 : SWMAX + 1))
                chk(rd ? "R7 read busy bound" : "R7 write busy bound", 32'(cnt),
                    32'(rd ? SWMAX + 2 : SWMAX + 1));
            if (rd) check_read_back(a, (int'(a) >= DEPTH) ? "R10 read" : "R5 read");
        end

        // R7 worst case: switch holds the memory SW_RUN_MAX cycles
        set_src_code(8'hC3, 6'h1E);
        do_access(1'b0, 8'd40, 2, SWMAX, cnt);
        chk("R7 worst write busy", 32'(cnt), 32'(SWMAX + 1));
        sw_read_chk(8'd40, "R4 worst write stored");
        do_access(1'b1, 8'd77, 2, SWMAX, cnt);
        chk("R7 worst read busy", 32'(cnt), 32'(SWMAX + 2));
        check_read_back(8'd77, "R5 worst read");

        // R8/R9 collision and locked registers
        set_src_code(8'h3C, 6'h15);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = 2'd0; cpu_wdata = {1'b0, 8'd10}; sw_req = 1'b1; sw_addr = 8'd5;
        @(negedge clk);
        cpu_wdata = {1'b0, 8'd20};
        @(negedge clk);
        cpu_sel = 2'd1; cpu_wdata = 9'h0AA;
        @(negedge clk);
        cpu_wr = 1'b0; sw_req = 1'b0;
        @(negedge clk);
        model[10] = {6'h15, 8'h3C};
        rd_reg(2'd3, v); chk("R8 collision flag set", 32'(v), 32'd2);
        rd_reg(2'd0, v); chk("R8 address kept", 32'(v), 32'd10);
        rd_reg(2'd1, v); chk("R9 data write ignored", 32'(v), 32'h3C);
        sw_read_chk(8'd10, "R8 first access stored");
        sw_read_chk(8'd20, "R8 second address untouched");
        do_access(1'b0, 8'd30, 0, 0, cnt);
        rd_reg(2'd3, v); chk("R8 flag sticky", 32'(v), 32'd2);
        wr_reg(2'd3, 9'h002);
        rd_reg(2'd3, v); chk("R8 flag cleared", 32'(v), 32'd0);

        // R9 code write during busy
        set_src_code(8'h11, 6'h22);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = 2'd0; cpu_wdata = {1'b0, 8'd50}; sw_req = 1'b1; sw_addr = 8'd1;
        @(negedge clk);
        cpu_sel = 2'd2; cpu_wdata = 9'h03F;
        @(negedge clk);
        cpu_wr = 1'b0; sw_req = 1'b0;
        @(negedge clk);
        model[50] = {6'h22, 8'h11};
        rd_reg(2'd2, v); chk("R9 code write ignored", 32'(v), 32'h22);
        sw_read_chk(8'd50, "R9 word uses held code");

        // R10 out-of-range write and read
        set_src_code(8'hEE, 6'h3D);
        do_access(1'b0, 8'd200, 0, 0, cnt);
        sw_read_chk(8'd8, "R10 no alias after write");
        do_access(1'b1, 8'd255, 0, 0, cnt);
        check_read_back(8'd255, "R10 read");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule